// File: doc/BRIEF.md
# I2C Address-Phase Status Flags

This block keeps the three status bits of a two-wire serial interface that are settled by the first byte after a start condition. The bits are a reserved-code flag (the upper nibble of the received first byte is all zeros or all ones), an address-hit flag (the received seven-bit address equals the programmed node address), and a transmit-direction flag that says whether this node now drives the data line. A registered data-line output enable is derived from the direction flag.

The block sits behind a line-sampling front end that delivers single-cycle strobes for detected start and stop conditions and for clock rising and falling edges, a bit counter for the current byte, and the received byte. Control logic supplies the node address, an enable level, a release command, a wait-release command, an arbitration-lost level, the master/slave mode level, a pulse for each start the node generates itself, and the direction bit it sends as master. All outputs are registered and change on the clock edge that samples the event.

Top module: `i2c_afl_status`

## Requirements
- R1: On a clock-rise strobe with bit count 8 during the first byte after a start, the reserved-code flag becomes 1 on the next edge when received bits 7:4 are 4'b0000 or 4'b1111; otherwise it stays 0.
- R2: On the same eighth-rise strobe of the first byte, the address-hit flag becomes 1 when received bits 7:1 equal the 7-bit node address; otherwise it stays 0.
- R3: The reserved-code and address-hit flags return to 0 on a detected start, a generated start, a detected stop, the release command, or while the enable input is 0.
- R4: In master mode a generated-start pulse sets the direction flag; the eighth-rise strobe of the first byte clears it when the sent direction bit is 1 and leaves it set when that bit is 0.
- R5: In slave mode a detected start clears the direction flag; the eighth-rise strobe of the first byte sets it when received bit 0 is 1 and the address hits, and leaves it 0 otherwise. A generated-start pulse has no effect in slave mode.
- R6: The direction flag returns to 0 on a detected stop, the release command, the enable input being 0, and a 0-to-1 change of the arbitration-lost input.
- R7: The data-line output enable is 1 only while the direction flag is 1 and a clock-fall strobe with bit count 9 of the first byte has been seen since the flag was set; it rises on the edge that samples that strobe.
- R8: A wait-release command with bit count 9 while the direction flag is 1 clears both the flag and the output enable; with any other bit count it has no effect.
- R9: Eighth-rise strobes of bytes after the first (no start in between) change neither the reserved-code, address-hit nor direction flag.
- R10: A clearing event always wins over a setting event on the same edge (a start strobe together with an eighth-rise strobe leaves all flags 0).
- R11: A synchronous active-high reset forces all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable level |
| rel_cmd_i | input | 1 | Release-from-communication command pulse |
| wrel_cmd_i | input | 1 | Wait-release command pulse |
| arb_lost_i | input | 1 | Arbitration-lost level |
| is_master_i | input | 1 | 1 = master mode, 0 = slave mode |
| start_gen_i | input | 1 | Pulse: this node generated a start |
| start_det_i | input | 1 | Pulse: start condition detected on the bus |
| stop_det_i | input | 1 | Pulse: stop condition detected on the bus |
| scl_rise_i | input | 1 | Pulse: clock-line rising edge |
| scl_fall_i | input | 1 | Pulse: clock-line falling edge |
| bit_cnt_i | input | 4 | Index (1..9) of the current clock within the byte |
| rx_byte_i | input | 8 | Received byte, complete at the eighth rising edge |
| tx_dir_bit_i | input | 1 | Direction bit sent as master in the first byte |
| node_addr_i | input | 7 | Programmed node address |
| rsv_code_o | output | 1 | Reserved-code flag |
| addr_hit_o | output | 1 | Address-hit flag |
| xmit_o | output | 1 | Transmit-direction flag |
| sda_oe_o | output | 1 | Data-line output enable |

## Verification
A wrong internal state shows at the flags one edge after the strobe that should have changed them: a missed first-byte window leaves the reserved-code or address-hit flag 0 after an eighth-rise strobe, or lets a data byte change it. A stale direction flag shows either at the next eighth rise or as the output enable rising after a ninth-clock fall when it should not. The bench sweeps all 256 first-byte values against two node addresses in slave mode and both direction bits in master mode, then probes every clearing event and the priority corner.

// File: rtl/i2c_afl_pkg.sv
package i2c_afl_pkg;

  // Decoded single-cycle events shared by the flag units.
  typedef struct packed {
    logic hard_clr;   // release command or interface disabled
    logic start_any;  // detected or self-generated start
    logic start_slv;  // detected start while in slave mode
    logic gen;        // self-generated start while in master mode
    logic stop;       // detected stop
    logic eighth;     // eighth rising clock of the first byte
    logic ninth_fall; // ninth falling clock of the first byte
    logic arb_rise;   // arbitration-lost went 0 -> 1
    logic wrel9;      // wait release with the count at the ninth clock
  } afl_ev_t;

endpackage

// File: rtl/i2c_afl_events.sv
module i2c_afl_events
  import i2c_afl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int ADDR_CLK = 8,
  parameter int ACK_CLK  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rel_cmd_i,
  input  logic             wrel_cmd_i,
  input  logic             arb_lost_i,
  input  logic             is_master_i,
  input  logic             start_gen_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  output afl_ev_t          ev_o,
  output logic             first_byte_o
);

  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_CLK);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(ACK_CLK);

  logic first_q;
  logic arb_q;
  logic gen_w;
  logic hard_w;

  assign gen_w  = start_gen_i & is_master_i;
  assign hard_w = rel_cmd_i | ~en_i;

  always_comb begin
    ev_o            = '0;
    ev_o.hard_clr   = hard_w;
    ev_o.start_any  = start_det_i | gen_w;
    ev_o.start_slv  = start_det_i & ~is_master_i;
    ev_o.gen        = gen_w;
    ev_o.stop       = stop_det_i;
    ev_o.eighth     = first_q & scl_rise_i & (bit_cnt_i == CNT_ADDR);
    ev_o.ninth_fall = first_q & scl_fall_i & (bit_cnt_i == CNT_ACK);
    ev_o.arb_rise   = arb_lost_i & ~arb_q;
    ev_o.wrel9      = wrel_cmd_i & (bit_cnt_i == CNT_ACK);
  end

  // First-byte window: opened by any start, closed after the ninth clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      arb_q <= arb_lost_i;
      if (hard_w || stop_det_i)
        first_q <= 1'b0;
      else if (start_det_i || gen_w)
        first_q <= 1'b1;
      else if (ev_o.ninth_fall)
        first_q <= 1'b0;
    end
  end

  assign first_byte_o = first_q;

  // R9: window closes after the ninth falling clock of the first byte
  a_r9_window_closes: assert property (@(posedge clk) disable iff (rst)
    (ev_o.ninth_fall && !start_det_i && !gen_w) |=> !first_q);

endmodule

// File: rtl/i2c_afl_addr_flags.sv
module i2c_afl_addr_flags
  import i2c_afl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 7,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  afl_ev_t           ev_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              hit_now_o,
  output logic              rsv_o,
  output logic              hit_o
);

  localparam int CODE_LO = BYTE_W - CODE_W;

  logic [ADDR_W-1:0] eq_bits;
  logic [CODE_W-1:0] code;
  logic              rsv_now;
  logic              rsv_q;
  logic              hit_q;
  logic              clr;

  // Bitwise compare of the address field (bits above the direction bit).
  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    assign eq_bits[i] = (rx_byte_i[i + BYTE_W - ADDR_W] == node_addr_i[i]);
  end

  assign code      = rx_byte_i[BYTE_W-1:CODE_LO];
  assign rsv_now   = (&code) | ~(|code);
  assign hit_now_o = ev_i.eighth & (&eq_bits);
  assign clr       = ev_i.hard_clr | ev_i.start_any | ev_i.stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_q <= 1'b0;
      hit_q <= 1'b0;
    end else if (clr) begin
      rsv_q <= 1'b0;
      hit_q <= 1'b0;
    end else if (ev_i.eighth) begin
      rsv_q <= rsv_q | rsv_now;
      hit_q <= hit_q | (&eq_bits);
    end
  end

  assign rsv_o = rsv_q;
  assign hit_o = hit_q;

  // R1: reserved-code flag only rises after an eighth-clock strobe
  a_r1_rsv_needs_eighth: assert property (@(posedge clk) disable iff (rst)
    $rose(rsv_q) |-> $past(ev_i.eighth));
  // R2: address-hit flag only rises after an eighth-clock strobe
  a_r2_hit_needs_eighth: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_q) |-> $past(ev_i.eighth));
  // R3: stop leaves both flags low
  a_r3_clear_on_stop: assert property (@(posedge clk) disable iff (rst)
    ev_i.stop |=> (!rsv_q && !hit_q));
  // R10: a start on the same edge as the eighth strobe wins
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (ev_i.start_any && ev_i.eighth) |=> (!rsv_q && !hit_q));

endmodule

// File: rtl/i2c_afl_dir_ctl.sv
module i2c_afl_dir_ctl
  import i2c_afl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  afl_ev_t ev_i,
  input  logic    is_master_i,
  input  logic    tx_dir_bit_i,
  input  logic    rx_lsb_i,
  input  logic    hit_now_i,
  output logic    xmit_o,
  output logic    oe_o
);

  logic xmit_q, armed_q, oe_q;
  logic xmit_n, armed_n;
  logic kill;

  assign kill = ev_i.hard_clr | ev_i.stop | ev_i.arb_rise | (ev_i.wrel9 & xmit_q);

  always_comb begin
    xmit_n  = xmit_q;
    armed_n = armed_q;
    if (kill) begin
      xmit_n  = 1'b0;
      armed_n = 1'b0;
    end else if (ev_i.start_slv) begin
      xmit_n  = 1'b0;
      armed_n = 1'b0;
    end else if (ev_i.gen) begin
      xmit_n  = 1'b1;
      armed_n = 1'b0;
    end else if (ev_i.start_any) begin
      armed_n = 1'b0;
    end else if (ev_i.eighth) begin
      if (is_master_i) begin
        if (tx_dir_bit_i) xmit_n = 1'b0;
      end else if (rx_lsb_i && hit_now_i) begin
        xmit_n = 1'b1;
      end
    end else if (ev_i.ninth_fall && xmit_q) begin
      armed_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xmit_q  <= 1'b0;
      armed_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      xmit_q  <= xmit_n;
      armed_q <= armed_n;
      oe_q    <= xmit_n & armed_n;
    end
  end

  assign xmit_o = xmit_q;
  assign oe_o   = oe_q;

  // R6: arbitration loss drops the direction flag
  a_r6_arb_clears: assert property (@(posedge clk) disable iff (rst)
    ev_i.arb_rise |=> !xmit_q);
  // R6: disabled interface never transmits
  a_r6_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    ev_i.hard_clr |=> (!xmit_q && !oe_q));
  // R7: output enable rises only after the ninth falling clock
  a_r7_oe_after_ninth: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(ev_i.ninth_fall));
  // R8: wait release at the ninth clock ends transmission
  a_r8_wrel_clears: assert property (@(posedge clk) disable iff (rst)
    (ev_i.wrel9 && xmit_q) |=> (!xmit_q && !oe_q));

endmodule

// File: rtl/i2c_afl_status.sv
module i2c_afl_status
  import i2c_afl_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int CODE_W   = 4,
  parameter int CNT_W    = 4,
  parameter int ADDR_CLK = 8,
  parameter int ACK_CLK  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              rel_cmd_i,
  input  logic              wrel_cmd_i,
  input  logic              arb_lost_i,
  input  logic              is_master_i,
  input  logic              start_gen_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              tx_dir_bit_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              rsv_code_o,
  output logic              addr_hit_o,
  output logic              xmit_o,
  output logic              sda_oe_o
);

  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_CLK);

  afl_ev_t ev;
  logic    first_byte;
  logic    hit_now;

  i2c_afl_events #(
    .CNT_W(CNT_W), .ADDR_CLK(ADDR_CLK), .ACK_CLK(ACK_CLK)
  ) u_events (
    .clk(clk), .rst(rst), .en_i(en_i), .rel_cmd_i(rel_cmd_i),
    .wrel_cmd_i(wrel_cmd_i), .arb_lost_i(arb_lost_i),
    .is_master_i(is_master_i), .start_gen_i(start_gen_i),
    .start_det_i(start_det_i), .stop_det_i(stop_det_i),
    .scl_rise_i(scl_rise_i), .scl_fall_i(scl_fall_i),
    .bit_cnt_i(bit_cnt_i), .ev_o(ev), .first_byte_o(first_byte)
  );

  i2c_afl_addr_flags #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)
  ) u_addr (
    .clk(clk), .rst(rst), .ev_i(ev), .rx_byte_i(rx_byte_i),
    .node_addr_i(node_addr_i), .hit_now_o(hit_now),
    .rsv_o(rsv_code_o), .hit_o(addr_hit_o)
  );

  i2c_afl_dir_ctl u_dir (
    .clk(clk), .rst(rst), .ev_i(ev), .is_master_i(is_master_i),
    .tx_dir_bit_i(tx_dir_bit_i), .rx_lsb_i(rx_byte_i[0]),
    .hit_now_i(hit_now), .xmit_o(xmit_o), .oe_o(sda_oe_o)
  );

  // R9: eighth-clock strobes of later bytes leave all flags unchanged
  a_r9_data_byte_quiet: assert property (@(posedge clk) disable iff (rst)
    (scl_rise_i && bit_cnt_i == CNT_ADDR && !first_byte && en_i && !rel_cmd_i
     && !start_det_i && !start_gen_i && !stop_det_i && !arb_lost_i && !wrel_cmd_i)
    |=> ($stable(rsv_code_o) && $stable(addr_hit_o) && $stable(xmit_o)));
  // R11: reset clears every output
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (!rsv_code_o && !addr_hit_o && !xmit_o && !sda_oe_o));

endmodule

// File: tb/tb_i2c_afl_status.sv
module tb_i2c_afl_status;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b1, rel_cmd_i = 0, wrel_cmd_i = 0, arb_lost_i = 0;
  logic       is_master_i = 0, start_gen_i = 0, start_det_i = 0, stop_det_i = 0;
  logic       scl_rise_i = 0, scl_fall_i = 0, tx_dir_bit_i = 0;
  logic [3:0] bit_cnt_i = 4'd1;
  logic [7:0] rx_byte_i = 8'h00;
  logic [6:0] node_addr_i = 7'h2A;
  logic       rsv_code_o, addr_hit_o, xmit_o, sda_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_afl_status dut (.*);

  task automatic tick();
    @(posedge clk);
    #2;
    start_det_i = 0; stop_det_i = 0; start_gen_i = 0;
    scl_rise_i = 0; scl_fall_i = 0; rel_cmd_i = 0; wrel_cmd_i = 0;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic all_zero(input string req);
    chk(req, rsv_code_o, 1'b0);
    chk(req, addr_hit_o, 1'b0);
    chk(req, xmit_o, 1'b0);
    chk(req, sda_oe_o, 1'b0);
  endtask

  task automatic rise8(input logic [7:0] b);
    bit_cnt_i = 4'd8; rx_byte_i = b; scl_rise_i = 1; tick();
  endtask

  task automatic fall9();
    bit_cnt_i = 4'd9; scl_fall_i = 1; tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    all_zero("R11 reset");
    rst = 0; tick();

    // Slave sweep: every first byte against two node addresses (R1 R2 R5 R7 R9 R3)
    for (int a = 0; a < 2; a++) begin
      node_addr_i = (a == 0) ? 7'h2A : 7'h7F;
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b;
        logic e_rsv, e_hit, e_tx;
        b = 8'(v);
        e_rsv = (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
        e_hit = (b[7:1] == node_addr_i);
        e_tx  = b[0] && e_hit;
        start_det_i = 1; tick();
        chk("R5 slave start", xmit_o, 1'b0);
        rise8(b);
        chk("R1 rsv flag", rsv_code_o, e_rsv);
        chk("R2 hit flag", addr_hit_o, e_hit);
        chk("R5 slave dir", xmit_o, e_tx);
        chk("R7 oe before ninth", sda_oe_o, 1'b0);
        fall9();
        chk("R7 oe after ninth", sda_oe_o, e_tx);
        rise8(~b);
        chk("R9 data rsv", rsv_code_o, e_rsv);
        chk("R9 data hit", addr_hit_o, e_hit);
        chk("R9 data dir", xmit_o, e_tx);
        stop_det_i = 1; tick();
        all_zero("R3 R6 stop");
      end
    end

    // Generated start ignored in slave mode (R5)
    start_gen_i = 1; tick();
    chk("R5 gen ignored in slave", xmit_o, 1'b0);

    // Master: both direction bits (R4 R7 R8)
    is_master_i = 1;
    for (int d = 0; d < 2; d++) begin
      start_gen_i = 1; tick();
      chk("R4 master start sets", xmit_o, 1'b1);
      chk("R7 master oe idle", sda_oe_o, 1'b0);
      tx_dir_bit_i = d[0];
      rise8(8'h55);
      chk("R4 master dir", xmit_o, !d[0]);
      fall9();
      chk("R7 master oe", sda_oe_o, !d[0]);
      bit_cnt_i = 4'd5; wrel_cmd_i = 1; tick();
      chk("R8 wrel other count", xmit_o, !d[0]);
      chk("R8 wrel other count oe", sda_oe_o, !d[0]);
      bit_cnt_i = 4'd9; wrel_cmd_i = 1; tick();
      chk("R8 wrel ninth", xmit_o, 1'b0);
      chk("R8 wrel ninth oe", sda_oe_o, 1'b0);
      stop_det_i = 1; tick();
    end

    // Arbitration loss (R6)
    start_gen_i = 1; tick();
    chk("R6 pre arb", xmit_o, 1'b1);
    arb_lost_i = 1; tick();
    chk("R6 arb rise", xmit_o, 1'b0);
    arb_lost_i = 0; tick();

    // Release and disable clear flags (R3 R6)
    is_master_i = 0; node_addr_i = 7'h00;
    start_det_i = 1; tick();
    rise8(8'h01);
    chk("R3 setup rsv", rsv_code_o, 1'b1);
    chk("R5 setup dir", xmit_o, 1'b1);
    rel_cmd_i = 1; tick();
    all_zero("R3 R6 release");
    start_det_i = 1; tick();
    rise8(8'h01);
    en_i = 0; tick();
    all_zero("R3 R6 disable");
    en_i = 1;
    rise8(8'h01);
    all_zero("R9 no window after disable");

    // Start together with eighth strobe (R10)
    start_det_i = 1; tick();
    start_det_i = 1; bit_cnt_i = 4'd8; rx_byte_i = 8'h01; scl_rise_i = 1; tick();
    all_zero("R10 clear wins");

    // Mid-run reset (R11)
    rise8(8'h01);
    chk("R11 pre reset", addr_hit_o, 1'b1);
    rst = 1; tick();
    all_zero("R11 mid reset");
    rst = 0; tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule